// File: doc/BRIEF.md
# Byte-Buffered SPI Master

This block is an SPI master for 8-bit words, run from a small byte-wide register file. Software writes up to eight transmit bytes into a local buffer. It sets a byte count, a clock divider and the clock mode. A single write to the control register then starts a burst. The block shifts the selected bytes out on MOSI and captures the same number of bytes from MISO. Each received byte is written back into the slot whose byte was just sent. At the end of the burst the go bit clears by itself and a completion flag is raised.

SCLK is derived from the block clock, which acts as the fixed reference, by an 8-bit divider. Clock polarity, clock phase and bit order are set from the mode register. Three active-low slave-select lines are driven either directly from a raw bit field or from a decoded device index. An interrupt line combines the two status flags with their enables. Software sequences longer transfers by running one burst after another.

Top module: `spi_burst_master`

## Requirements
- R1: After reset ss_o is 3'b111, sclk_o is 0, irq_o is 0, the status register (address 0x5) reads 0 and the divider register (address 0x2) reads 255.
- R2: Select/length register (0x3): bits 2:0 form the select field and bit 3 chooses decoded mode. In raw mode ss_o equals the field. In decoded mode, line i is low only when the field equals i, so index 7 raises every line.
- R3: During a burst one SCLK period lasts max(divider,2) block clock cycles. A write to the divider register is ignored while divider-enable (bit 2 of register 0x1) is set.
- R4: A write to control (0x4) with bit 2 and bit 3 both set starts a burst only if mode bit 4 (enable) and divider-enable are set. Control bit 3 reads 1 while the burst runs and 0 after it ends. With mode bit 4 clear the write starts nothing.
- R5: Bits 6:4 of register 0x3 hold the byte count minus one. Exactly that many bytes go out, from buffer slot 0 (address 0x8) upward. Slots beyond the count keep their contents.
- R6: SCLK rests at CPOL (mode bit 2) whenever no burst runs. With CPHA (mode bit 1) at 0, MOSI holds the first bit before the first SCLK edge, MISO is sampled on leading edges and MOSI changes on trailing edges. With CPHA at 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R7: Mode bit 3 set sends and receives each byte least significant bit first. Clear, the most significant bit goes first.
- R8: After a burst, each slot that was sent holds the byte received during that slot.
- R9: Status bit 0 is set when a burst completes and bit 1 is set on a transceiver error. Writing 1 to a bit clears only that bit. irq_o is high when (bit 0 and control bit 6) or (bit 1 and control bit 7).
- R10: Writing control with bit 3 set while a burst runs sets status bit 1, and the write is otherwise ignored. The running burst completes with correct data.
- R11: While a burst runs, writes to the mode, clock, divider, select/length and buffer registers are ignored, and ss_o never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_o | output | 3 | Slave selects, active low |
| ss_oe_o | output | 1 | Select output enable (mode bit 7) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench acts as a behavioural SPI slave and runs bursts in all four CPOL/CPHA combinations, with both bit orders. Byte counts of 1, 2, 3, 4 and 8 tell the length decode apart from off-by-one errors. Slave bytes differ from the transmit bytes, so a missing write-back or an overrun into unused slots is visible. Divider values 1, 2, 3, 4 and 5 separate the even and odd half-period split and the lower clamp. Bursts with a go write, a select write, a mode write and a buffer write landing mid-burst tell the ignore and error paths apart from normal completion.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_MODE = 4'h0;
  localparam logic [ADDR_W-1:0] A_CLK  = 4'h1;
  localparam logic [ADDR_W-1:0] A_DIV  = 4'h2;
  localparam logic [ADDR_W-1:0] A_SEL  = 4'h3;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h4;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h5;

  localparam int unsigned M_CPHA = 1;
  localparam int unsigned M_CPOL = 2;
  localparam int unsigned M_LSB  = 3;
  localparam int unsigned M_EN   = 4;
  localparam int unsigned M_SSOE = 7;

  localparam int unsigned K_DIVEN = 2;

  localparam int unsigned S_DEC     = 3;
  localparam int unsigned S_LEN_LSB = 4;

  localparam int unsigned C_BUF  = 2;
  localparam int unsigned C_GO   = 3;
  localparam int unsigned C_CIE  = 6;
  localparam int unsigned C_EIE  = 7;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             lead_o,
  output logic             trail_o
);
  logic [DIV_W-1:0] cnt_q, d_eff, half;

  assign d_eff   = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
  assign half    = d_eff >> 1;
  assign lead_o  = run_i && (cnt_q == half - DIV_W'(1));
  assign trail_o = run_i && (cnt_q == d_eff - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (trail_o)  cnt_q <= '0;
    else               cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_ss_map.sv
module spi_ss_map #(
  parameter int unsigned SS_N = 3
) (
  input  logic [SS_N-1:0] field_i,
  input  logic            decode_i,
  output logic [SS_N-1:0] ss_o
);
  for (genvar g = 0; g < SS_N; g++) begin : g_line
    assign ss_o[g] = decode_i ? (field_i != SS_N'(g)) : field_i[g];
  end
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int unsigned NBYTES = 8,
  localparam int unsigned IDX_W = $clog2(NBYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             lsb_i,
  input  logic [IDX_W-1:0] last_idx_i,
  input  logic             lead_i,
  input  logic             trail_i,
  input  logic             miso_i,
  input  logic [7:0]       tx_cur_i,
  input  logic [7:0]       tx_nxt_i,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic             rx_we_o,
  output logic [7:0]       rx_byte_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sclk_o,
  output logic             mosi_o
);
  logic             busy_q, phase_q, mosi_q;
  logic [2:0]       bit_q;
  logic [IDX_W-1:0] byte_q;
  logic [7:0]       rx_q, rx_in;
  logic             last_bit, last_byte;

  function automatic logic [2:0] pos(input logic [2:0] b, input logic lsb);
    return lsb ? b : 3'd7 - b;
  endfunction

  assign rx_in     = lsb_i ? {miso_i, rx_q[7:1]} : {rx_q[6:0], miso_i};
  assign last_bit  = (bit_q == 3'd7);
  assign last_byte = (byte_q == last_idx_i);
  assign rx_we_o   = busy_q && trail_i && last_bit;
  assign rx_byte_o = cpha_i ? rx_in : rx_q;  // CPHA=1 samples on this very edge
  assign done_o    = rx_we_o && last_byte;
  assign busy_o    = busy_q;
  assign byte_idx_o = byte_q;
  assign sclk_o    = cpol_i ^ phase_q;
  assign mosi_o    = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; phase_q <= 1'b0; mosi_q <= 1'b0;
      bit_q <= '0; byte_q <= '0; rx_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      bit_q   <= '0;
      byte_q  <= '0;
      mosi_q  <= tx_cur_i[pos(3'd0, lsb_i)];
    end else if (busy_q) begin
      if (lead_i) begin
        phase_q <= 1'b1;
        if (!cpha_i) rx_q   <= rx_in;
        else         mosi_q <= tx_cur_i[pos(bit_q, lsb_i)];
      end
      if (trail_i) begin
        phase_q <= 1'b0;
        if (cpha_i) rx_q <= rx_in;
        if (last_bit) begin
          bit_q <= '0;
          if (last_byte) begin
            busy_q <= 1'b0;
            byte_q <= '0;
          end else begin
            byte_q <= byte_q + IDX_W'(1);
            if (!cpha_i) mosi_q <= tx_nxt_i[pos(3'd0, lsb_i)];
          end
        end else begin
          bit_q <= bit_q + 3'd1;
          if (!cpha_i) mosi_q <= tx_cur_i[pos(bit_q + 3'd1, lsb_i)];
        end
      end
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int unsigned NBYTES = 8,
  parameter int unsigned SS_N   = 3,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [SS_N-1:0]   ss_o,
  output logic              ss_oe_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = $clog2(NBYTES);

  logic [7:0]       mode_q, clk_q, ctrl_q, sel_q;
  logic [DIV_W-1:0] div_q;
  logic             sts_done_q, sts_err_q;
  logic [7:0]       buf_q [NBYTES];

  logic             busy, done, rx_we, lead, trail, idle_wr, start, go_busy;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       rx_byte;

  assign idle_wr = we_i && !busy;
  assign start   = idle_wr && (addr_i == A_CTRL) && wdata_i[C_GO] && wdata_i[C_BUF]
                   && mode_q[M_EN] && clk_q[K_DIVEN];
  assign go_busy = we_i && busy && (addr_i == A_CTRL) && wdata_i[C_GO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0; clk_q <= '0; ctrl_q <= '0;
      sel_q  <= 8'h07; div_q <= '1;
    end else if (idle_wr) begin
      unique case (addr_i)
        A_MODE: mode_q <= wdata_i;
        A_CLK:  clk_q  <= wdata_i;
        A_DIV:  if (!clk_q[K_DIVEN]) div_q <= wdata_i[DIV_W-1:0];
        A_SEL:  sel_q  <= {1'b0, wdata_i[6:0]};
        A_CTRL: ctrl_q <= wdata_i & ~(8'd1 << C_GO);
        default: ;
      endcase
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_done_q <= 1'b0;
      sts_err_q  <= 1'b0;
    end else begin
      if (done)                                        sts_done_q <= 1'b1;
      else if (we_i && addr_i == A_STAT && wdata_i[0]) sts_done_q <= 1'b0;
      if (go_busy)                                     sts_err_q  <= 1'b1;
      else if (we_i && addr_i == A_STAT && wdata_i[1]) sts_err_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBYTES; i++) buf_q[i] <= '0;
    end else begin
      for (int i = 0; i < NBYTES; i++) begin
        if (rx_we && byte_idx == IDX_W'(i))
          buf_q[i] <= rx_byte;
        else if (idle_wr && addr_i[3] && addr_i[IDX_W-1:0] == IDX_W'(i))
          buf_q[i] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[3]) rdata_o = buf_q[addr_i[IDX_W-1:0]];
    else begin
      unique case (addr_i)
        A_MODE: rdata_o = mode_q;
        A_CLK:  rdata_o = clk_q;
        A_DIV:  rdata_o = 8'(div_q);
        A_SEL:  rdata_o = sel_q;
        A_CTRL: rdata_o = ctrl_q | (8'(busy) << C_GO);
        A_STAT: rdata_o = {6'd0, sts_err_q, sts_done_q};
        default: rdata_o = '0;
      endcase
    end
  end

  assign irq_o   = (sts_done_q && ctrl_q[C_CIE]) || (sts_err_q && ctrl_q[C_EIE]);
  assign ss_oe_o = mode_q[M_SSOE];

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i(busy), .div_i(div_q), .lead_o(lead), .trail_o(trail)
  );

  spi_ss_map #(.SS_N(SS_N)) u_ss (
    .field_i(sel_q[SS_N-1:0]), .decode_i(sel_q[S_DEC]), .ss_o(ss_o)
  );

  spi_bit_engine #(.NBYTES(NBYTES)) u_eng (
    .clk_i, .rst_ni, .start_i(start),
    .cpol_i(mode_q[M_CPOL]), .cpha_i(mode_q[M_CPHA]), .lsb_i(mode_q[M_LSB]),
    .last_idx_i(sel_q[S_LEN_LSB +: IDX_W]),
    .lead_i(lead), .trail_i(trail), .miso_i,
    .tx_cur_i(buf_q[byte_idx]), .tx_nxt_i(buf_q[byte_idx + IDX_W'(1)]),
    .byte_idx_o(byte_idx), .rx_we_o(rx_we), .rx_byte_o(rx_byte),
    .busy_o(busy), .done_o(done), .sclk_o, .mosi_o
  );
endmodule

// File: rtl/spi_burst_chk.sv
module spi_burst_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       cpol_i,
  input logic       sclk_i,
  input logic       mosi_i,
  input logic [2:0] ss_i,
  input logic       irq_i,
  input logic       done_i,
  input logic       err_i
);
  a_r6_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> sclk_i == cpol_i);

  a_r11_ss_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(ss_i));

  a_r9_irq_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> done_i || err_i);

  a_r4_go_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);

  a_r6_mosi_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) && $stable(sclk_i) |-> $stable(mosi_i));
endmodule

bind spi_burst_master spi_burst_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .cpol_i(mode_q[2]),
  .sclk_i(sclk_o), .mosi_i(mosi_o), .ss_i(ss_o), .irq_i(irq_o),
  .done_i(sts_done_q), .err_i(sts_err_q)
);

// File: tb/spi_burst_master_tb_top.sv
`timescale 1ns/1ps
module spi_burst_master_tb_top;
  logic       clk_i = 1'b0, rst_ni = 1'b0, we_i = 1'b0, miso_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       sclk_o, mosi_o, ss_oe_o, irq_o;
  logic [2:0] ss_o;

  spi_burst_master dut_i (.*);

  always #2.5 clk_i = ~clk_i;

  int  checks = 0, fails = 0, cyc = 0;
  bit  live = 0, in_burst = 0;
  bit  cfg_cpol = 0, cfg_cpha = 0;
  logic [2:0] exp_ss = 3'b111;
  bit  s_bits[64];
  int  s_k = 0;
  bit  m_cap[$];
  int  last_lead = -1, period = 0;
  logic prev_sclk = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] ss_model(input logic [7:0] v);
    logic [2:0] r;
    for (int i = 0; i < 3; i++) r[i] = v[3] ? (v[2:0] != 3'(i)) : v[i];
    return r;
  endfunction

  // per-clock compare and behavioural slave
  always @(negedge clk_i) begin
    cyc++;
    if (live) begin
      if (!in_burst) begin
        chk("R6 idle sclk", sclk_o, cfg_cpol);
        chk("R2 ss", ss_o, exp_ss);
      end else begin
        if (prev_sclk == cfg_cpol && sclk_o != cfg_cpol) begin
          if (last_lead >= 0) period = cyc - last_lead;
          last_lead = cyc;
          if (!cfg_cpha) m_cap.push_back(mosi_o);
          else begin miso_i = s_bits[s_k]; s_k++; end
        end else if (prev_sclk != cfg_cpol && sclk_o == cfg_cpol) begin
          if (cfg_cpha) m_cap.push_back(mosi_o);
          else begin s_k++; if (s_k < 64) miso_i = s_bits[s_k]; end
        end
      end
    end
    prev_sclk = sclk_o;
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i); #1;
    we_i = 1'b1; addr_i = a; wdata_i = d;
    if (!in_burst && a == 4'h0) cfg_cpol = d[2];
    if (!in_burst && a == 4'h3) exp_ss = ss_model(d);
    @(posedge clk_i); #1;
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i); #1;
    addr_i = a; #1;
    d = rdata_o;
  endtask

  task automatic run_burst(input bit cpol, input bit cpha, input bit lsb, input logic [7:0] div,
                           input int n, input logic [63:0] tx, input logic [63:0] sl,
                           input logic [7:0] ie, input bit poke);
    logic [7:0] d, mode;
    int to, k;
    mode = {1'b1, 2'b00, 1'b1, lsb, cpol, cpha, 1'b0};
    wr(4'h0, mode);
    wr(4'h1, 8'h00);
    wr(4'h2, div);
    wr(4'h1, 8'h04);
    for (int i = 0; i < 8; i++) wr(4'(8 + i), tx[8*i +: 8]);
    wr(4'h3, {1'b0, 3'(n - 1), 1'b0, 3'b110});
    for (int b = 0; b < n; b++)
      for (int j = 0; j < 8; j++) s_bits[8*b + j] = sl[8*b + (lsb ? j : 7 - j)];
    m_cap.delete(); s_k = 0; last_lead = -1; period = 0;
    cfg_cpha = cpha; miso_i = s_bits[0];
    in_burst = 1;
    wr(4'h4, ie | 8'h0C);
    rd(4'h4, d); chk("R4 go reads set while busy", d[3], 1'b1);
    if (poke) begin
      repeat (6) @(negedge clk_i);
      wr(4'h4, ie | 8'h0C);
      rd(4'h5, d); chk("R10 error flag on busy go", d[1], 1'b1);
      wr(4'h3, 8'h03);
      wr(4'h0, 8'h00);
      wr(4'hF, 8'hEE);
      wr(4'h2, 8'h11);
    end
    to = 0;
    do begin rd(4'h5, d); to++; end while (!d[0] && to < 30000);
    in_burst = 0;
    chk("R5 bit count", m_cap.size(), 8 * n);
    k = 0;
    for (int b = 0; b < n; b++)
      for (int j = 0; j < 8; j++) begin
        if (k < m_cap.size())
          chk("R6/R7 mosi bit", m_cap[k], tx[8*b + (lsb ? j : 7 - j)]);
        k++;
      end
    for (int i = 0; i < 8; i++) begin
      rd(4'(8 + i), d);
      if (i < n) chk("R8 rx in slot", d, sl[8*i +: 8]);
      else       chk("R5 unused slot kept", d, tx[8*i +: 8]);
    end
    chk("R3 sclk period", period, (div < 2) ? 2 : div);
    rd(4'h4, d); chk("R4 go self-clear", d[3], 1'b0);
    rd(4'h5, d); chk("R9 status after burst", d, poke ? 8'h03 : 8'h01);
    chk("R9 irq", irq_o, ie[6] | (poke & ie[7]));
    if (poke) begin
      rd(4'h0, d); chk("R11 mode write ignored", d, mode);
      rd(4'h2, d); chk("R11 div write ignored", d, div);
      chk("R11 ss held", ss_o, 3'b110);
      wr(4'h5, 8'h01);
      rd(4'h5, d); chk("R9 w1c done only", d, 8'h02);
      chk("R9 irq from err", irq_o, ie[7]);
    end
    wr(4'h5, 8'h03);
    rd(4'h5, d); chk("R9 status cleared", d, 8'h00);
    chk("R9 irq low", irq_o, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    live = 1;
    chk("R1 ss reset", ss_o, 3'b111);
    chk("R1 sclk reset", sclk_o, 1'b0);
    chk("R1 irq reset", irq_o, 1'b0);
    rd(4'h5, d); chk("R1 status reset", d, 8'h00);
    rd(4'h2, d); chk("R1 divider reset", d, 8'hFF);

    wr(4'h3, 8'h05); chk("R2 raw field", ss_o, 3'b101);
    wr(4'h3, 8'h09); chk("R2 decoded index 1", ss_o, 3'b101);
    wr(4'h3, 8'h0A); chk("R2 decoded index 2", ss_o, 3'b011);
    wr(4'h3, 8'h08); chk("R2 decoded index 0", ss_o, 3'b110);
    wr(4'h3, 8'h0F); chk("R2 decoded index 7", ss_o, 3'b111);
    wr(4'h3, 8'h07); chk("R2 raw all ones", ss_o, 3'b111);

    run_burst(0, 0, 0, 8'd4, 3, 64'h8877_6655_4433_22A5, 64'h0000_0000_00C3_3C96, 8'h40, 0);
    run_burst(1, 1, 1, 8'd5, 8, 64'h0102_0408_1020_4080, 64'hF00F_AA55_1234_5678, 8'h40, 0);
    run_burst(0, 1, 0, 8'd1, 1, 64'h7766_5544_3322_1181, 64'h0000_0000_0000_0042, 8'h00, 0);
    run_burst(1, 0, 1, 8'd2, 2, 64'h9988_7766_5544_D32C, 64'h0000_0000_0000_E71B, 8'hC0, 1);
    run_burst(0, 0, 0, 8'd3, 4, 64'h1357_9BDF_0246_8ACE, 64'h0000_0000_5AA5_C36E, 8'h80, 1);

    wr(4'h2, 8'h09);
    rd(4'h2, d); chk("R3 divider locked while enabled", d, 8'h03);

    wr(4'h0, 8'h80);
    wr(4'h4, 8'h0C);
    rd(4'h4, d); chk("R4 no start when disabled", d[3], 1'b0);
    repeat (20) @(negedge clk_i);
    rd(4'h5, d); chk("R4 no completion when disabled", d, 8'h00);

    live = 0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule